// File: doc/BRIEF.md
# Grouped assertion stop and status collector

This block sits between a bank of hard-wired hardware assertion checkers and the run-stop debug logic of a chip. Each checker drives a one-bit fire signal. The checkers are switched on and off in groups of `GROUP_SIZE` neighbouring assertions, with one enable bit per group. At design time each assertion is classed either as an error or as a warning through the parameter vector `ERR_MASK`.

An enabled error raises a level stop request toward the clock-stop logic and acts like a hardware breakpoint. An enabled warning never halts the system. Every enabled firing of either class is held in a sticky status bit until the debug port collects it. Several firings of the same assertion between two collections produce a single bit, and they are not counted.

A serial debug port stands in for the test access port. A capture strobe moves the sticky bits into a shift chain and clears them. A shift strobe moves the chain one bit per clock, least significant bit first. An update strobe copies the low bits of the chain into the group enable register. A separate clear strobe drops the stop request.

Top module: `asg_collector`

## Requirements
- R1: Assertion i belongs to group i / GROUP_SIZE (integer division). Enable bit g of the group enable register gates every assertion of group g, where 1 means enabled.
- R2: A firing assertion in a disabled group leaves the stop request low and sets no status bit.
- R3: An enabled assertion whose `ERR_MASK` bit is 1 (error) sets `stop_req` at the clock edge that samples the firing.
- R4: An enabled assertion whose `ERR_MASK` bit is 0 (warning) never raises `stop_req`, but its status bit is set in the same way as an error's.
- R5: `stop_req` is a level. It stays high after the firing drops, and it goes low at the edge that samples `dbg_stop_clear`. If an enabled error fires in the same cycle as the clear, the request stays high.
- R6: A status bit, once set, stays set until a capture. Repeated firings before that capture leave exactly one set bit.
- R7: At the edge that samples `dbg_capture`, the chain is loaded with the status bits as they were before that edge, and the status is cleared. An enabled firing in the capture cycle is kept set and appears at the following capture.
- R8: With `dbg_shift` high (and `dbg_capture` low), the chain moves one place toward bit 0 on each clock. `dbg_tdo` shows chain bit 0, and `dbg_tdi` enters at bit N_ASSERT-1. Status bit i is therefore read out as the (i+1)-th bit after a capture. Capture takes priority over shift.
- R9: At the edge that samples `dbg_update`, chain bits N_GROUP-1..0 are written into the group enable register. After shifting in N_ASSERT bits of value v, LSB first, the register holds v's low N_GROUP bits.
- R10: Synchronous reset clears the stop request, all status bits, the chain and the group enable register, so all groups start disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| assert_fire | input | N_ASSERT | Fire signals from the assertion checkers |
| dbg_capture | input | 1 | Capture strobe: status into the chain, then clear the status |
| dbg_shift | input | 1 | Shift the chain by one bit |
| dbg_update | input | 1 | Load the group enables from the chain |
| dbg_stop_clear | input | 1 | Drop the stop request |
| dbg_tdi | input | 1 | Serial data into the chain |
| dbg_tdo | output | 1 | Serial data out of the chain (chain bit 0) |
| stop_req | output | 1 | Level stop request toward the clock-stop logic |

## Verification
The hardest case to reach from the ports is a firing that lands in the same cycle as a capture strobe. That firing has to be missing from the value being read out and present at the next read. The bench drives the fire pulse and the capture strobe from the same negative clock edge and then runs two full readouts back to back. A simultaneous error firing and stop clear is provoked the same way. The main sweep covers every group enable pattern crossed with every single-assertion firing and with an all-assertions firing. For each case it computes the expected stop level and the expected read-back word arithmetically from the group mapping and the class mask.

// File: rtl/asg_pkg.sv
package asg_pkg;

    // Debug port strobes gathered into one command word
    typedef struct packed {
        logic capture;
        logic shift;
        logic update;
        logic stop_clear;
    } dbg_cmd_t;

    // Group that an assertion index belongs to
    function automatic int unsigned group_of(input int unsigned idx,
                                             input int unsigned gsize);
        return idx / gsize;
    endfunction

endpackage

// File: rtl/asg_group_gate.sv
module asg_group_gate
    import asg_pkg::*;
#(
    parameter int unsigned N_ASSERT   = 8,
    parameter int unsigned GROUP_SIZE = 2,
    parameter logic [N_ASSERT-1:0] ERR_MASK = 8'b0101_0011,
    localparam int unsigned N_GROUP = N_ASSERT / GROUP_SIZE
) (
    input  logic [N_GROUP-1:0]  grp_en,
    input  logic [N_ASSERT-1:0] fire,
    output logic [N_ASSERT-1:0] hits,
    output logic                err_any
);

    logic [N_ASSERT-1:0] err_hits;

    for (genvar i = 0; i < N_ASSERT; i++) begin : g_gate
        localparam int unsigned GRP = group_of(i, GROUP_SIZE);
        assign hits[i]     = fire[i] & grp_en[GRP];
        assign err_hits[i] = hits[i] & ERR_MASK[i];
    end

    assign err_any = |err_hits;

endmodule

// File: rtl/asg_sticky_status.sv
module asg_sticky_status #(
    parameter int unsigned N_ASSERT = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_ASSERT-1:0] hits,
    input  logic                capture,
    output logic [N_ASSERT-1:0] status
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (capture) begin
            // old bits leave with the capture; fresh hits stay for the next one
            status <= hits;
        end else begin
            status <= status | hits;
        end
    end

    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> (($past(status) & ~status) == '0));

endmodule

// File: rtl/asg_stop_ctrl.sv
module asg_stop_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic err_any,
    input  logic clear,
    output logic stop_req
);

    always_ff @(posedge clk) begin
        if (rst)          stop_req <= 1'b0;
        else if (err_any) stop_req <= 1'b1;
        else if (clear)   stop_req <= 1'b0;
    end

    p_stop_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stop_req && !clear) |=> stop_req);

    p_stop_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (clear && !err_any) |=> !stop_req);

endmodule

// File: rtl/asg_scan_chain.sv
module asg_scan_chain #(
    parameter int unsigned N_ASSERT = 8,
    parameter int unsigned N_GROUP  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic                shift,
    input  logic                update,
    input  logic                tdi,
    input  logic [N_ASSERT-1:0] status_in,
    output logic                tdo,
    output logic [N_GROUP-1:0]  grp_en
);

    logic [N_ASSERT-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else if (capture) begin
            chain <= status_in;
        end else if (shift) begin
            chain <= {tdi, chain[N_ASSERT-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         grp_en <= '0;
        else if (update) grp_en <= chain[N_GROUP-1:0];
    end

    assign tdo = chain[0];

    p_capture_load_r7: assert property (@(posedge clk) disable iff (rst)
        capture |=> (chain == $past(status_in)));

    p_shift_move_r8: assert property (@(posedge clk) disable iff (rst)
        (shift && !capture) |=> (chain[N_ASSERT-2:0] == $past(chain[N_ASSERT-1:1])));

    p_update_load_r9: assert property (@(posedge clk) disable iff (rst)
        update |=> (grp_en == $past(chain[N_GROUP-1:0])));

endmodule

// File: rtl/asg_collector.sv
module asg_collector
    import asg_pkg::*;
#(
    parameter int unsigned N_ASSERT   = 8,
    parameter int unsigned GROUP_SIZE = 2,
    parameter logic [N_ASSERT-1:0] ERR_MASK = 8'b0101_0011
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [N_ASSERT-1:0] assert_fire,
    input  logic                dbg_capture,
    input  logic                dbg_shift,
    input  logic                dbg_update,
    input  logic                dbg_stop_clear,
    input  logic                dbg_tdi,
    output logic                dbg_tdo,
    output logic                stop_req
);

    localparam int unsigned N_GROUP = N_ASSERT / GROUP_SIZE;

    dbg_cmd_t            cmd;
    logic [N_GROUP-1:0]  grp_en;
    logic [N_ASSERT-1:0] hits;
    logic [N_ASSERT-1:0] status;
    logic                err_any;

    assign cmd = '{capture: dbg_capture, shift: dbg_shift,
                   update: dbg_update, stop_clear: dbg_stop_clear};

    asg_group_gate #(.N_ASSERT(N_ASSERT), .GROUP_SIZE(GROUP_SIZE), .ERR_MASK(ERR_MASK))
    u_gate (
        .grp_en (grp_en),
        .fire   (assert_fire),
        .hits   (hits),
        .err_any(err_any)
    );

    asg_sticky_status #(.N_ASSERT(N_ASSERT)) u_status (
        .clk    (clk),
        .rst    (rst),
        .hits   (hits),
        .capture(cmd.capture),
        .status (status)
    );

    asg_stop_ctrl u_stop (
        .clk     (clk),
        .rst     (rst),
        .err_any (err_any),
        .clear   (cmd.stop_clear),
        .stop_req(stop_req)
    );

    asg_scan_chain #(.N_ASSERT(N_ASSERT), .N_GROUP(N_GROUP)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .capture  (cmd.capture),
        .shift    (cmd.shift),
        .update   (cmd.update),
        .tdi      (dbg_tdi),
        .status_in(status),
        .tdo      (dbg_tdo),
        .grp_en   (grp_en)
    );

    // Per-assertion enable, expanded from the group register for checking
    logic [N_ASSERT-1:0] en_exp;
    for (genvar i = 0; i < N_ASSERT; i++) begin : g_exp
        assign en_exp[i] = grp_en[group_of(i, GROUP_SIZE)];
    end

    p_disabled_group_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((status & ~$past(status) & ~$past(en_exp)) == '0));

    p_warn_no_stop_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_req) |-> $past((assert_fire & en_exp & ERR_MASK) != '0));

endmodule

// File: tb/asg_collector_tb_top.sv
module asg_collector_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NA = 8;
    localparam int unsigned GS = 2;
    localparam int unsigned NG = NA / GS;
    localparam logic [NA-1:0] EMASK = 8'b0101_0011;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NA-1:0] assert_fire = '0;
    logic dbg_capture = 1'b0, dbg_shift = 1'b0, dbg_update = 1'b0;
    logic dbg_stop_clear = 1'b0, dbg_tdi = 1'b0;
    logic dbg_tdo, stop_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    asg_collector #(.N_ASSERT(NA), .GROUP_SIZE(GS), .ERR_MASK(EMASK)) dut_i (
        .clk(clk), .rst(rst), .assert_fire(assert_fire),
        .dbg_capture(dbg_capture), .dbg_shift(dbg_shift), .dbg_update(dbg_update),
        .dbg_stop_clear(dbg_stop_clear), .dbg_tdi(dbg_tdi),
        .dbg_tdo(dbg_tdo), .stop_req(stop_req)
    );

    function automatic logic [NA-1:0] expand(input logic [NG-1:0] en);
        logic [NA-1:0] r;
        for (int i = 0; i < NA; i++) r[i] = en[i / GS];
        return r;
    endfunction

    task automatic check(input string req, input logic [NA-1:0] act,
                         input logic [NA-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic program_en(input logic [NA-1:0] v);
        dbg_shift = 1'b1;
        for (int i = 0; i < NA; i++) begin
            dbg_tdi = v[i];
            @(negedge clk);
        end
        dbg_shift = 1'b0;
        dbg_tdi = 1'b0;
        dbg_update = 1'b1;
        @(negedge clk);
        dbg_update = 1'b0;
    endtask

    // Capture then shift the whole chain out; returns bits in index order
    task automatic read_status(output logic [NA-1:0] r);
        dbg_capture = 1'b1;
        @(negedge clk);
        dbg_capture = 1'b0;
        for (int i = 0; i < NA; i++) begin
            r[i] = dbg_tdo;
            dbg_shift = 1'b1;
            @(negedge clk);
        end
        dbg_shift = 1'b0;
    endtask

    task automatic pulse_fire(input logic [NA-1:0] f);
        assert_fire = f;
        @(negedge clk);
        assert_fire = '0;
    endtask

    task automatic clear_stop();
        dbg_stop_clear = 1'b1;
        @(negedge clk);
        dbg_stop_clear = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [NA-1:0] rd;
        logic [NA-1:0] hit;
        logic [NA-1:0] f;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10: reset state
        check("R10 stop", {7'b0, stop_req}, '0);
        check("R10 tdo", {7'b0, dbg_tdo}, '0);
        read_status(rd);
        check("R10 status", rd, '0);

        // R2, R10: enables come out of reset cleared, so nothing registers
        pulse_fire('1);
        check("R2 stop after reset", {7'b0, stop_req}, '0);
        read_status(rd);
        check("R2 status after reset", rd, '0);

        // R1 R2 R3 R4 R8 R9: sweep enable patterns against firing patterns
        for (int en = 0; en < (1 << NG); en++) begin
            program_en(NA'(en));
            for (int a = 0; a <= NA; a++) begin
                f = (a == NA) ? '1 : (NA'(1) << a);
                hit = f & expand(NG'(en));
                pulse_fire(f);
                check("R3 R4 stop level", {7'b0, stop_req}, {7'b0, |(hit & EMASK)});
                repeat (2) @(negedge clk);
                check("R5 stop held", {7'b0, stop_req}, {7'b0, |(hit & EMASK)});
                read_status(rd);
                check("R1 R2 R8 status", rd, hit);
                clear_stop();
                check("R5 stop cleared", {7'b0, stop_req}, '0);
            end
        end

        // R6: repeated firings merge into one bit
        program_en('1);
        pulse_fire(8'h04);
        @(negedge clk);
        pulse_fire(8'h04);
        pulse_fire(8'h04);
        check("R4 warning no stop", {7'b0, stop_req}, '0);
        read_status(rd);
        check("R6 merged bit", rd, 8'h04);
        read_status(rd);
        check("R6 cleared after capture", rd, '0);

        // R7: firing in the capture cycle is kept for the next capture
        pulse_fire(8'h08);
        assert_fire = 8'h20;
        dbg_capture = 1'b1;
        @(negedge clk);
        assert_fire = '0;
        dbg_capture = 1'b0;
        for (int i = 0; i < NA; i++) begin
            rd[i] = dbg_tdo;
            dbg_shift = 1'b1;
            @(negedge clk);
        end
        dbg_shift = 1'b0;
        check("R7 first capture", rd, 8'h08);
        read_status(rd);
        check("R7 second capture", rd, 8'h20);

        // R8: capture wins over shift in the same cycle
        pulse_fire(8'h80);
        dbg_capture = 1'b1;
        dbg_shift = 1'b1;
        @(negedge clk);
        dbg_capture = 1'b0;
        dbg_shift = 1'b0;
        for (int i = 0; i < NA; i++) begin
            rd[i] = dbg_tdo;
            dbg_shift = 1'b1;
            @(negedge clk);
        end
        dbg_shift = 1'b0;
        check("R8 capture priority", rd, 8'h80);

        // R5: error firing together with clear keeps the request high
        clear_stop();
        pulse_fire(8'h01);
        check("R3 stop set", {7'b0, stop_req}, 8'h01);
        assert_fire = 8'h02;
        dbg_stop_clear = 1'b1;
        @(negedge clk);
        assert_fire = '0;
        dbg_stop_clear = 1'b0;
        check("R5 set beats clear", {7'b0, stop_req}, 8'h01);
        clear_stop();
        check("R5 clear after", {7'b0, stop_req}, '0);

        // R9: only the low bits of the chain reach the enables
        program_en(8'hF4);
        read_status(rd);
        pulse_fire('1);
        read_status(rd);
        check("R9 enables from low bits", rd, expand(4'h4));
        clear_stop();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule